// File: doc/BRIEF.md
# Replaying DAC Sample Buffer

This block sits between a DMA stream clocked by the system clock and a DAC transport path clocked by the device clock. In loop mode it takes one DMA transfer into local storage. It records how many beats arrived, and from then on it plays those samples to the DAC side over and over, with no gap between the end of one pass and the start of the next. This lets a converter run at sample rates that the memory path could not sustain on its own.

When the bypass control is high, the buffer stops replaying. Each incoming sample then passes through a small asynchronous FIFO, so the DMA has to keep up with the DAC by itself. The bypass input is treated as asynchronous and is synchronized into both clock domains.

The write side is a valid/ready/last stream. The read side presents one sample per device-clock cycle together with a valid flag. The stored length crosses the domains through a toggle handshake. While that handshake is pending, the write side holds off new beats.

Top module: `dac_loop_buffer`

## Requirements
- R1: After reset, `d_valid` is low and, in loop mode, `s_ready` is high.
- R2: In loop mode, `d_valid` stays low until a transfer that ends with `s_last` has been captured.
- R3: After a loop-mode transfer of N beats, the output presents the stored samples in arrival order, starting with the first beat.
- R4: Replay wraps from sample N-1 back to sample 0 on the very next cycle, with `d_valid` held high across the wrap.
- R5: The first accepted beat of a new transfer halts replay (`d_valid` low) until that transfer's last beat is captured. Replay then restarts from its first sample. While the length is being handed over, the stored length does not change.
- R6: A one-beat transfer makes the output repeat that single sample on every cycle.
- R7: Beats beyond the storage depth (64 samples by default) are dropped, and the replay length is limited to that depth.
- R8: With bypass high, every accepted beat appears once at the output, in order. `s_ready` is low whenever the bypass FIFO is full.
- R9: With bypass high and the bypass FIFO empty, `d_valid` is low.
- R10: Any change of the bypass input discards the loaded state. After leaving bypass, `d_valid` stays low until a new transfer is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | System (write-side) clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| rclk | input | 1 | Device (read-side) clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| bypass | input | 1 | Asynchronous mode select: 1 = stream through, 0 = load and replay |
| s_valid | input | 1 | Write beat valid |
| s_ready | output | 1 | Write beat accepted when high together with `s_valid` |
| s_data | input | SAMPLE_W | Write sample |
| s_last | input | 1 | Marks the final beat of a transfer |
| d_data | output | SAMPLE_W | Sample toward the DAC transport |
| d_valid | output | 1 | `d_data` holds a real sample |

## Verification
A stale or wrong replay length shows up at the output within one pass. Either a sample past the end is repeated, or the wrap comes early, so comparing two full loops of known data exposes it. A read address that fails to wrap, or that skips a step, shows as a wrong value on the next valid cycle. A loaded flag that is not cleared when a transfer starts or the mode changes shows as `d_valid` staying high a few device cycles after the event. In bypass, a pointer fault appears as a duplicated, missing or out-of-order sample in the streamed sequence.

// File: rtl/lpbuf_pkg.sv
package lpbuf_pkg;

    parameter int unsigned SAMPLE_W = 16;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t data;
        logic    last;
    } beat_t;

    typedef enum logic {
        SRC_LOOP   = 1'b0,
        SRC_STREAM = 1'b1
    } out_src_t;

    // Binary to reflected-binary conversion; callers slice the width they need.
    function automatic logic [31:0] to_gray(logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/lpbuf_sync2.sv
module lpbuf_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lpbuf_ram.sv
module lpbuf_ram
    import lpbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  sample_t           wdata,
    input  logic              rclk,
    input  logic [ADDR_W-1:0] raddr,
    output sample_t           rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    sample_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // One cycle of read latency; the read controller aligns valid to it.
    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/lpbuf_async_fifo.sv
module lpbuf_async_fifo
    import lpbuf_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic    wclk,
    input  logic    wrst,
    input  logic    push,
    input  sample_t wdata,
    output logic    full,
    input  logic    rclk,
    input  logic    rrst,
    input  logic    pop,
    output sample_t rdata,
    output logic    empty
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    sample_t       mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, wgray_r;
    logic [PW-1:0] wbin_nx, rbin_nx;
    logic [31:0]   wg_full, rg_full;

    assign wbin_nx = wbin + 1'b1;
    assign rbin_nx = rbin + 1'b1;
    assign wg_full = to_gray(32'(wbin_nx));
    assign rg_full = to_gray(32'(rbin_nx));

    always_ff @(posedge wclk) begin
        if (push) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin_nx;
            wgray <= wg_full[PW-1:0];
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin_nx;
            rgray <= rg_full[PW-1:0];
        end
    end

    lpbuf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w));
    lpbuf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r));

    assign full  = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    assign empty = (rgray == wgray_r);
    assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/lpbuf_wr_ctrl.sv
module lpbuf_wr_ctrl
    import lpbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              byp_w,
    input  logic              s_valid,
    input  beat_t             beat,
    output logic              s_ready,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output sample_t           ram_wdata,
    output logic              filling,
    output logic [ADDR_W:0]   len_hold,
    output logic              req_t,
    input  logic              ack_w,
    output logic              busy
);
    localparam int unsigned LEN_W = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic             in_xfer;
    logic [LEN_W-1:0] cnt, idx, nxt;
    logic             room, acc;

    assign busy      = (req_t != ack_w);
    assign s_ready   = byp_w ? !fifo_full : !busy;
    assign acc       = s_valid && s_ready;
    assign idx       = in_xfer ? cnt : '0;
    assign room      = idx < LEN_W'(DEPTH);
    assign nxt       = room ? idx + 1'b1 : idx;
    assign fifo_push = acc && byp_w;
    assign ram_we    = acc && !byp_w && room;
    assign ram_waddr = idx[ADDR_W-1:0];
    assign ram_wdata = beat.data;
    assign filling   = in_xfer;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            in_xfer  <= 1'b0;
            cnt      <= '0;
            len_hold <= '0;
            req_t    <= 1'b0;
        end else if (byp_w) begin
            in_xfer <= 1'b0;
        end else if (acc) begin
            cnt <= nxt;
            if (beat.last) begin
                in_xfer  <= 1'b0;
                len_hold <= nxt;
                req_t    <= ~req_t;
            end else begin
                in_xfer <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpbuf_rd_ctrl.sv
module lpbuf_rd_ctrl #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              rclk,
    input  logic              rrst,
    input  logic              byp_r,
    input  logic              fill_r,
    input  logic              req_r,
    input  logic [ADDR_W:0]   len_in,
    output logic              ack_t,
    output logic [ADDR_W-1:0] raddr,
    output logic              loop_v,
    output logic              loaded,
    output logic              active,
    output logic              cap,
    output logic [ADDR_W:0]   len
);
    logic fill_d, byp_d, at_end, drop;

    assign cap    = (req_r != ack_t);
    assign active = loaded && !fill_r && !byp_r;
    assign at_end = ({1'b0, raddr} + 1'b1) == len;
    assign drop   = (fill_r && !fill_d) || (byp_r != byp_d);

    always_ff @(posedge rclk) begin
        if (rrst) begin
            ack_t  <= 1'b0;
            raddr  <= '0;
            loop_v <= 1'b0;
            loaded <= 1'b0;
            len    <= '0;
            fill_d <= 1'b0;
            byp_d  <= 1'b0;
        end else begin
            fill_d <= fill_r;
            byp_d  <= byp_r;
            loop_v <= active;
            if (cap) begin
                ack_t  <= req_r;
                len    <= len_in;
                loaded <= (len_in != '0);
                raddr  <= '0;
            end else if (active) begin
                raddr <= at_end ? '0 : raddr + 1'b1;
            end
            if (drop) loaded <= 1'b0;
        end
    end
endmodule

// File: rtl/dac_loop_buffer.sv
module dac_loop_buffer
    import lpbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BYP_AW = 3
) (
    input  logic                wclk,
    input  logic                wrst,
    input  logic                rclk,
    input  logic                rrst,
    input  logic                bypass,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_data,
    input  logic                s_last,
    output logic [SAMPLE_W-1:0] d_data,
    output logic                d_valid
);
    localparam int unsigned LEN_W = ADDR_W + 1;

    logic              byp_w, byp_r;
    logic              req_t, ack_t, req_r, ack_w;
    logic              fill_w, fill_r, w_busy;
    logic [LEN_W-1:0]  w_len, r_len;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr, rd_addr;
    sample_t           ram_wdata, ram_q;
    logic              fifo_push, fifo_full, fifo_pop, fifo_empty;
    sample_t           fifo_q, byp_q;
    logic              byp_v, loop_v;
    logic              r_loaded, r_active, r_cap;
    beat_t             in_beat;
    out_src_t          src;

    assign in_beat = '{data: s_data, last: s_last};

    lpbuf_sync2 #(.W(1)) u_byp_w (.clk(wclk), .rst(wrst), .d(bypass), .q(byp_w));
    lpbuf_sync2 #(.W(1)) u_byp_r (.clk(rclk), .rst(rrst), .d(bypass), .q(byp_r));
    lpbuf_sync2 #(.W(1)) u_req   (.clk(rclk), .rst(rrst), .d(req_t),  .q(req_r));
    lpbuf_sync2 #(.W(1)) u_fill  (.clk(rclk), .rst(rrst), .d(fill_w), .q(fill_r));
    lpbuf_sync2 #(.W(1)) u_ack   (.clk(wclk), .rst(wrst), .d(ack_t),  .q(ack_w));

    lpbuf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk(wclk), .wrst(wrst), .byp_w(byp_w), .s_valid(s_valid), .beat(in_beat),
        .s_ready(s_ready), .fifo_full(fifo_full), .fifo_push(fifo_push),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .filling(fill_w), .len_hold(w_len), .req_t(req_t), .ack_w(ack_w), .busy(w_busy)
    );

    lpbuf_ram #(.ADDR_W(ADDR_W)) u_ram (
        .wclk(wclk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .rclk(rclk), .raddr(rd_addr), .rdata(ram_q)
    );

    lpbuf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .rclk(rclk), .rrst(rrst), .byp_r(byp_r), .fill_r(fill_r), .req_r(req_r),
        .len_in(w_len), .ack_t(ack_t), .raddr(rd_addr), .loop_v(loop_v),
        .loaded(r_loaded), .active(r_active), .cap(r_cap), .len(r_len)
    );

    lpbuf_async_fifo #(.AW(BYP_AW)) u_fifo (
        .wclk(wclk), .wrst(wrst), .push(fifo_push), .wdata(s_data), .full(fifo_full),
        .rclk(rclk), .rrst(rrst), .pop(fifo_pop), .rdata(fifo_q), .empty(fifo_empty)
    );

    // The DAC side takes a sample every cycle, so pop whenever data is present.
    assign fifo_pop = byp_r && !fifo_empty;

    always_ff @(posedge rclk) begin
        if (rrst) begin
            byp_q <= '0;
            byp_v <= 1'b0;
        end else begin
            byp_q <= fifo_q;
            byp_v <= fifo_pop;
        end
    end

    assign src = byp_r ? SRC_STREAM : SRC_LOOP;

    always_comb begin
        unique case (src)
            SRC_STREAM: begin
                d_data  = byp_q;
                d_valid = byp_v;
            end
            default: begin
                d_data  = ram_q;
                d_valid = loop_v;
            end
        endcase
    end
endmodule

// File: rtl/lpbuf_checker.sv
module lpbuf_checker #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              wclk,
    input logic              wrst,
    input logic              rclk,
    input logic              rrst,
    input logic              s_ready,
    input logic              d_valid,
    input logic              byp_w,
    input logic              byp_r,
    input logic              fifo_full,
    input logic              w_busy,
    input logic [ADDR_W:0]   w_len,
    input logic              r_loaded,
    input logic              r_active,
    input logic              r_cap,
    input logic [ADDR_W-1:0] r_addr,
    input logic [ADDR_W:0]   r_len
);
    p_idle_quiet_r2: assert property (@(posedge rclk) disable iff (rrst)
        (!byp_r && !r_loaded) |=> !d_valid);

    p_addr_range_r3: assert property (@(posedge rclk) disable iff (rrst)
        r_loaded |-> ({1'b0, r_addr} < r_len));

    p_addr_step_r3: assert property (@(posedge rclk) disable iff (rrst)
        (r_active && !r_cap && (({1'b0, r_addr} + 1'b1) != r_len))
        |=> (r_addr == $past(r_addr) + 1'b1));

    p_addr_wrap_r4: assert property (@(posedge rclk) disable iff (rrst)
        (r_active && (({1'b0, r_addr} + 1'b1) == r_len)) |=> (r_addr == '0));

    p_len_hold_r5: assert property (@(posedge wclk) disable iff (wrst)
        w_busy |=> $stable(w_len));

    p_len_nonzero_r6: assert property (@(posedge rclk) disable iff (rrst)
        r_loaded |-> (r_len != '0));

    p_no_overflow_r8: assert property (@(posedge wclk) disable iff (wrst)
        (byp_w && fifo_full) |-> !s_ready);

    p_mode_drop_r10: assert property (@(posedge rclk) disable iff (rrst)
        (byp_r != $past(byp_r)) |=> !r_loaded);
endmodule

bind dac_loop_buffer lpbuf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
    .s_ready(s_ready), .d_valid(d_valid), .byp_w(byp_w), .byp_r(byp_r),
    .fifo_full(fifo_full), .w_busy(w_busy), .w_len(w_len),
    .r_loaded(r_loaded), .r_active(r_active), .r_cap(r_cap),
    .r_addr(rd_addr), .r_len(r_len)
);

// File: tb/tb_dac_loop_buffer.sv
module tb_dac_loop_buffer;
    import lpbuf_pkg::*;

    logic    wclk = 1'b0, rclk = 1'b0;
    logic    wrst = 1'b1, rrst = 1'b1;
    logic    bypass = 1'b0, s_valid = 1'b0, s_last = 1'b0;
    sample_t s_data = '0;
    logic    s_ready, d_valid;
    sample_t d_data;

    int      checks = 0, fails = 0;
    bit      timed_out = 1'b0;
    sample_t pat [80];

    always #2 wclk = ~wclk;   // 250 MHz
    always #3 rclk = ~rclk;

    dac_loop_buffer dut (
        .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst), .bypass(bypass),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .d_data(d_data), .d_valid(d_valid)
    );

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic send(int first, int cnt, bit last_at_end);
        for (int k = first; k < first + cnt; k++) begin
            @(negedge wclk);
            s_valid = 1'b1;
            s_data  = pat[k];
            s_last  = last_at_end && (k == first + cnt - 1);
            while (!s_ready) @(negedge wclk);
            @(posedge wclk);
        end
        @(negedge wclk);
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic expect_low(int cycles, string tag);
        for (int k = 0; k < cycles; k++) begin
            @(negedge rclk);
            chk(!d_valid, tag, d_valid, 0);
        end
    endtask

    // First N samples checked under tag_a, the rest (wrapped passes) under tag_b.
    task automatic expect_loop(int n, int count, string tag_a, string tag_b);
        bit got = 1'b0;
        for (int t = 0; t < 300 && !got; t++) begin
            @(negedge rclk);
            got = d_valid;
        end
        chk(got, tag_a, got, 1);
        if (got) begin
            for (int k = 0; k < count; k++) begin
                if (k > 0) @(negedge rclk);
                chk(d_valid && d_data == pat[k % n], (k < n) ? tag_a : tag_b,
                    d_valid ? d_data : 32'hdead, pat[k % n]);
            end
        end
    endtask

    task automatic collect_stream(int n);
        for (int k = 0; k < n; k++) begin
            bit got = 1'b0;
            for (int t = 0; t < 100 && !got; t++) begin
                @(negedge rclk);
                got = d_valid;
            end
            chk(got && d_data == pat[k], "R8", got ? d_data : 32'hdead, pat[k]);
        end
    endtask

    task automatic t_reset;
        @(negedge wclk);
        chk(!d_valid, "R1", d_valid, 0);
        chk(s_ready, "R1", s_ready, 1);
    endtask

    task automatic t_unloaded;
        expect_low(30, "R2");
    endtask

    task automatic t_single;
        pat[0] = 16'h5A5A;
        send(0, 1, 1'b1);
        expect_loop(1, 12, "R6", "R6");
    endtask

    task automatic t_loop;
        for (int k = 0; k < 5; k++) pat[k] = sample_t'(16'h1000 + k * 3);
        send(0, 5, 1'b1);
        expect_loop(5, 17, "R3", "R4");
    endtask

    task automatic t_restart;
        for (int k = 0; k < 7; k++) pat[k] = sample_t'(16'h2000 + k * 7);
        send(0, 1, 1'b0);
        repeat (15) @(negedge rclk);
        expect_low(20, "R5");
        send(1, 6, 1'b1);
        expect_loop(7, 14, "R5", "R5");
    endtask

    task automatic t_overflow;
        for (int k = 0; k < 70; k++) pat[k] = sample_t'(16'hC000 + k);
        send(0, 70, 1'b1);
        expect_loop(64, 130, "R7", "R7");
    endtask

    task automatic t_enter_bypass;
        @(negedge wclk);
        bypass = 1'b1;
        repeat (20) @(negedge rclk);
        expect_low(10, "R10");
    endtask

    task automatic t_stream;
        for (int k = 0; k < 20; k++) pat[k] = sample_t'(16'h7700 + k * 5);
        fork
            send(0, 20, 1'b1);
            collect_stream(20);
        join
    endtask

    task automatic t_stream_empty;
        repeat (10) @(negedge rclk);
        expect_low(20, "R9");
    endtask

    task automatic t_leave_bypass;
        @(negedge wclk);
        bypass = 1'b0;
        repeat (20) @(negedge rclk);
        expect_low(20, "R10");
        for (int k = 0; k < 3; k++) pat[k] = sample_t'(16'hE100 + k);
        send(0, 3, 1'b1);
        expect_loop(3, 9, "R10", "R4");
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge wclk);
                wrst = 1'b0;
                @(negedge rclk);
                rrst = 1'b0;
                t_reset();
                t_unloaded();
                t_single();
                t_loop();
                t_restart();
                t_overflow();
                t_enter_bypass();
                t_stream();
                t_stream_empty();
                t_leave_bypass();
            end
            begin
                repeat (150000) @(posedge wclk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule